// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block is the transmit DMA front end of an Ethernet MAC. Software keeps a ring of fixed-size descriptors in memory, fills entries, and moves a write index forward. Whenever the engine's read index differs from that write index, the engine fetches the descriptor at its read index. It then streams the frame as a sequence of bytes toward the serializer, writes a status word back into the descriptor header, and steps its read index forward. It stops once the two indices are equal again.

Each descriptor is 16 words of 64 bits. Word 0 is the header. Bytes 8 to 127 form a 120-byte area. A frame may place some or all of its bytes inline at the tail of that area, so that they end exactly at descriptor byte 128. Up to two gather segments in memory follow the inline bytes. Each segment is described by an entry word and starts on an 8-byte boundary.

The header length decides how many bytes go out. The engine cuts off region bytes beyond that length, and fills with zeros up to the length, with a floor of 60 bytes. Memory answers a read one cycle after the request. Bytes are little-endian within a word.

Top module: `txring_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, rdIdx is 0, statusWord is 0, and outValid, outLast, txIrq, memRdEn and memWrEn are all low.
- R2: The engine processes one descriptor at a time whenever rdIdx differs from wrIdx. The header sits at word ringBase + 16*rdIdx. rdIdx advances by exactly one per descriptor, wraps modulo 2^IDX_W, and is reported in statusWord bits [16 +: IDX_W]. For a descriptor that holds only inline bytes, the first byte is valid on the 6th rising edge after wrIdx changes.
- R3: Header bits [22:16] hold the descriptor byte offset of the first inline byte, which is 128 minus the inline length and lies in 8..127. The inline bytes are descriptor bytes offset..127. An offset of 0 means there are no inline bytes, and output starts with segment 1.
- R4: Header bit 25 enables segment 1, whose entry is descriptor word 1. Header bit 26 enables segment 2, whose entry is word 2, and it counts only when bit 25 is also set. An entry holds the length minus one in bits [15:0] and the start word address (byte address divided by 8) in bits [16 +: AW]. Bytes go out in this order: inline, then segment 1, then segment 2.
- R5: With L = header[15:0] + 1, the frame is exactly max(L, 60) bytes long. The engine drops region bytes past that count and appends zero bytes when the regions are shorter.
- R6: When L exceeds MAX_FRAME (default 1518), no byte is sent. The header is written back with done (bit 32) and too-long (bit 34), and with success (bit 33) clear.
- R7: Every descriptor's header word is written back as the original header OR'ed with done in bit 32. Success (bit 33) is set when errIn was zero. errIn bits [3:0] (underrun, excessive collisions, deferral, late collision) are copied to bits [38:35]. errIn is sampled in the cycle in which outLast is high.
- R8: txIrq pulses high for one cycle, in the same cycle that rdIdx advances, when the descriptor's header bit 24 is set. It stays low when that bit is clear. statusWord bit 0 mirrors txIrq.
- R9: outLast is high together with outValid on exactly the final byte of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | AW | Word address of ring entry 0 |
| wrIdx | input | IDX_W | Software write index |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | AW | Word address for read or write |
| memRdData | input | 64 | Read data, one cycle after memRdEn |
| memWrEn | output | 1 | Header write-back strobe |
| memWrData | output | 64 | Header with status bits |
| errIn | input | 4 | Serializer error flags for the frame ending now |
| outValid | output | 1 | outByte carries a frame byte |
| outByte | output | 8 | Frame byte |
| outLast | output | 1 | Final byte of the frame |
| rdIdx | output | IDX_W | Engine read index |
| statusWord | output | 32 | rdIdx in bits 16 and up, txIrq in bit 0 |
| txIrq | output | 1 | Per-descriptor completion pulse |

## Verification
Memory read data is due one cycle after the request, and an output byte is valid one cycle after the engine reads it from its word buffer. An inline-only frame therefore shows its first byte on the sixth edge after the write index moves, and the bench counts falling edges to check that exact cycle. The write-back occurs in the cycle in which outLast is high, and rdIdx and txIrq change on the edge that follows. The bench gives errIn as a function of rdIdx, so that the value is already settled in the sampling cycle. The bench samples every output on the falling edge. Stream, status and interrupt checks run only after rdIdx has caught up with wrIdx, so they do not depend on timing between frames.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int HDR_OFF_LSB = 16;
  localparam int HDR_IEN_BIT = 24;
  localparam int HDR_SEG1_BIT = 25;
  localparam int HDR_SEG2_BIT = 26;
  localparam int ST_DONE_BIT = 32;
  localparam int ST_OK_BIT = 33;
  localparam int ST_LONG_BIT = 34;
  localparam int ST_ERR_LSB = 35;

  typedef struct packed {
    logic       capHdr;
    logic       capSeg1;
    logic       capSeg2;
    logic       loadReg;
    logic [1:0] regSel;
    logic       capWord;
    logic       emitData;
    logic       emitPad;
    logic       clearCnt;
    logic       tooLong;
  } txStrobe_t;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int AW = 10,
  parameter int MAX_FRAME = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [AW-1:0]    ringBase,
  input  logic [63:0]      memRdData,
  input  logic [AW-1:0]    curWord,
  input  logic             lastByte,
  input  logic             regEnd,
  input  logic             wordEnd,
  input  logic             hdrIntEn,
  output txStrobe_t        stb,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [AW-1:0]    memAddr,
  output logic [AW-1:0]    descBase,
  output logic [IDX_W-1:0] rdIdx,
  output logic             txIrq
);
  localparam int DESC_SH = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_SEG1, S_SEG2, S_NEXT, S_RD, S_LD, S_EMIT, S_PAD, S_WB
  } state_t;

  state_t     state;
  logic [2:0] pend;
  logic       tooLongR;
  logic       hdrTooLong;
  logic [1:0] pick;

  assign descBase   = ringBase + AW'({rdIdx, {DESC_SH{1'b0}}});
  assign hdrTooLong = memRdData[15:0] >= 16'(MAX_FRAME);
  assign pick       = pend[0] ? 2'd0 : (pend[1] ? 2'd1 : 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pend     <= '0;
      tooLongR <= 1'b0;
      rdIdx    <= '0;
      txIrq    <= 1'b0;
    end else begin
      txIrq <= 1'b0;
      case (state)
        S_IDLE: if (rdIdx != wrIdx) state <= S_HDR;
        S_HDR: begin
          pend <= {memRdData[HDR_SEG2_BIT] & memRdData[HDR_SEG1_BIT],
                   memRdData[HDR_SEG1_BIT], |memRdData[HDR_OFF_LSB +: 7]};
          tooLongR <= hdrTooLong;
          if (hdrTooLong) state <= S_WB;
          else if (memRdData[HDR_SEG1_BIT]) state <= S_SEG1;
          else state <= S_NEXT;
        end
        S_SEG1: state <= pend[2] ? S_SEG2 : S_NEXT;
        S_SEG2: state <= S_NEXT;
        S_NEXT: begin
          if (|pend) begin
            pend[pick] <= 1'b0;
            state <= S_RD;
          end else begin
            state <= S_PAD;
          end
        end
        S_RD: state <= S_LD;
        S_LD: state <= S_EMIT;
        S_EMIT: begin
          if (lastByte) state <= S_WB;
          else if (regEnd) state <= S_NEXT;
          else if (wordEnd) state <= S_RD;
        end
        S_PAD: if (lastByte) state <= S_WB;
        S_WB: begin
          rdIdx <= rdIdx + 1'b1;
          txIrq <= hdrIntEn;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    memRdEn  = 1'b0;
    memWrEn  = 1'b0;
    memAddr  = descBase;
    stb.tooLong = tooLongR;
    case (state)
      S_IDLE: memRdEn = (rdIdx != wrIdx);
      S_HDR: begin
        stb.capHdr   = 1'b1;
        stb.clearCnt = 1'b1;
        memRdEn = !hdrTooLong && memRdData[HDR_SEG1_BIT];
        memAddr = descBase + AW'(1);
      end
      S_SEG1: begin
        stb.capSeg1 = 1'b1;
        memRdEn = pend[2];
        memAddr = descBase + AW'(2);
      end
      S_SEG2: stb.capSeg2 = 1'b1;
      S_NEXT: begin
        stb.loadReg = |pend;
        stb.regSel  = pick;
      end
      S_RD: begin
        memRdEn = 1'b1;
        memAddr = curWord;
      end
      S_LD:   stb.capWord  = 1'b1;
      S_EMIT: stb.emitData = 1'b1;
      S_PAD:  stb.emitPad  = 1'b1;
      S_WB:   memWrEn = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/txr_dp.sv
module txr_dp
  import txr_pkg::*;
#(
  parameter int AW = 10,
  parameter int MIN_FRAME = 60
) (
  input  logic          clk,
  input  logic          rstN,
  input  txStrobe_t     stb,
  input  logic [63:0]   memRdData,
  input  logic [AW-1:0] descBase,
  input  logic [3:0]    errIn,
  output logic [AW-1:0] curWord,
  output logic          lastByte,
  output logic          regEnd,
  output logic          wordEnd,
  output logic          hdrIntEn,
  output logic [63:0]   memWrData,
  output logic          outValid,
  output logic [7:0]    outByte,
  output logic          outLast
);
  localparam int CNT_W = 17;

  logic [63:0]      hdr, seg1, seg2, wordBuf;
  logic [2:0]       lane;
  logic [CNT_W-1:0] remain, sent, hdrLen, total;
  logic [6:0]       inlOff;
  logic [63:0]      stat;

  assign inlOff   = hdr[HDR_OFF_LSB +: 7];
  assign hdrLen   = {1'b0, hdr[15:0]} + CNT_W'(1);
  assign total    = (hdrLen < CNT_W'(MIN_FRAME)) ? CNT_W'(MIN_FRAME) : hdrLen;
  assign lastByte = (sent == total - CNT_W'(1));
  assign regEnd   = (remain == CNT_W'(1));
  assign wordEnd  = (lane == 3'd7);
  assign hdrIntEn = hdr[HDR_IEN_BIT];

  always_comb begin
    stat = '0;
    stat[ST_DONE_BIT] = 1'b1;
    stat[ST_OK_BIT]   = !stb.tooLong && (errIn == 4'd0);
    stat[ST_LONG_BIT] = stb.tooLong;
    stat[ST_ERR_LSB +: 4] = stb.tooLong ? 4'd0 : errIn;
    memWrData = hdr | stat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdr      <= '0;
      seg1     <= '0;
      seg2     <= '0;
      wordBuf  <= '0;
      curWord  <= '0;
      lane     <= '0;
      remain   <= '0;
      sent     <= '0;
      outValid <= 1'b0;
      outByte  <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= stb.emitData | stb.emitPad;
      outLast  <= (stb.emitData | stb.emitPad) & lastByte;
      outByte  <= 8'd0;
      if (stb.capHdr)   hdr  <= memRdData;
      if (stb.capSeg1)  seg1 <= memRdData;
      if (stb.capSeg2)  seg2 <= memRdData;
      if (stb.capWord)  wordBuf <= memRdData;
      if (stb.clearCnt) sent <= '0;
      if (stb.loadReg) begin
        case (stb.regSel)
          2'd0: begin
            curWord <= descBase + AW'(inlOff[6:3]);
            lane    <= inlOff[2:0];
            remain  <= CNT_W'(128) - CNT_W'(inlOff);
          end
          2'd1: begin
            curWord <= seg1[16 +: AW];
            lane    <= '0;
            remain  <= {1'b0, seg1[15:0]} + CNT_W'(1);
          end
          default: begin
            curWord <= seg2[16 +: AW];
            lane    <= '0;
            remain  <= {1'b0, seg2[15:0]} + CNT_W'(1);
          end
        endcase
      end
      if (stb.emitData) begin
        outByte <= wordBuf[{lane, 3'b000} +: 8];
        lane    <= lane + 3'd1;
        remain  <= remain - CNT_W'(1);
        sent    <= sent + CNT_W'(1);
        if (wordEnd) curWord <= curWord + AW'(1);
      end
      if (stb.emitPad) sent <= sent + CNT_W'(1);
    end
  end
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
  import txr_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int AW = 10,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_FRAME = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    ringBase,
  input  logic [IDX_W-1:0] wrIdx,
  output logic             memRdEn,
  output logic [AW-1:0]    memAddr,
  input  logic [63:0]      memRdData,
  output logic             memWrEn,
  output logic [63:0]      memWrData,
  input  logic [3:0]       errIn,
  output logic             outValid,
  output logic [7:0]       outByte,
  output logic             outLast,
  output logic [IDX_W-1:0] rdIdx,
  output logic [31:0]      statusWord,
  output logic             txIrq
);
  txStrobe_t     stb;
  logic [AW-1:0] curWord, descBase;
  logic          lastByte, regEnd, wordEnd, hdrIntEn;

  txr_ctrl #(.IDX_W(IDX_W), .AW(AW), .MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrIdx(wrIdx), .ringBase(ringBase),
    .memRdData(memRdData), .curWord(curWord), .lastByte(lastByte),
    .regEnd(regEnd), .wordEnd(wordEnd), .hdrIntEn(hdrIntEn), .stb(stb),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .descBase(descBase), .rdIdx(rdIdx), .txIrq(txIrq)
  );

  txr_dp #(.AW(AW), .MIN_FRAME(MIN_FRAME)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdData(memRdData),
    .descBase(descBase), .errIn(errIn), .curWord(curWord),
    .lastByte(lastByte), .regEnd(regEnd), .wordEnd(wordEnd),
    .hdrIntEn(hdrIntEn), .memWrData(memWrData), .outValid(outValid),
    .outByte(outByte), .outLast(outLast)
  );

  assign statusWord = (32'(rdIdx) << 16) | 32'(txIrq);
endmodule

// File: rtl/txr_check.sv
module txr_check #(
  parameter int IDX_W = 3,
  parameter int MIN_FRAME = 60
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] rdIdx,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic             outValid,
  input logic             outLast,
  input logic             txIrq
);
  logic [16:0] byteCnt;

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= '0;
    else if (outValid) byteCnt <= outLast ? 17'd0 : byteCnt + 17'd1;
  end

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx != $past(rdIdx)) |-> (rdIdx == $past(rdIdx) + 1'b1));

  assert_wb_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (rdIdx == $past(rdIdx) + 1'b1));

  assert_no_port_clash_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  assert_min_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (byteCnt >= 17'(MIN_FRAME - 1)));

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_irq_advance_R8: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (rdIdx != $past(rdIdx)));
endmodule

bind txring_fetch txr_check #(.IDX_W(IDX_W), .MIN_FRAME(MIN_FRAME)) u_txr_check (
  .clk(clk), .rstN(rstN), .rdIdx(rdIdx), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .outValid(outValid), .outLast(outLast), .txIrq(txIrq)
);

// File: tb/test_txring_fetch.sv
`timescale 1ns/1ps
module test_txring_fetch;
  localparam int IDX_W = 3;
  localparam int AW = 10;
  localparam int NSLOT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] ringBase = '0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic memRdEn, memWrEn, outValid, outLast, txIrq;
  logic [AW-1:0] memAddr;
  logic [63:0] memRdData, memWrData;
  logic [3:0] errIn;
  logic [7:0] outByte;
  logic [IDX_W-1:0] rdIdx;
  logic [31:0] statusWord;

  logic [63:0] mem [0:(1<<AW)-1];
  logic [63:0] wbMem [0:NSLOT-1];
  logic [3:0]  errPlan [0:NSLOT-1];
  logic [63:0] expWb [0:NSLOT-1];
  logic [7:0]  expBytes[$], gotBytes[$];
  int          expLens[$], gotLens[$];
  int          gotRun = 0, irqCnt = 0, expIrq = 0;
  int          checks = 0, errors = 0, cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign errIn = errPlan[rdIdx];

  txring_fetch #(.IDX_W(IDX_W), .AW(AW)) i_txring_fetch (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .wrIdx(wrIdx),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .errIn(errIn),
    .outValid(outValid), .outByte(outByte), .outLast(outLast),
    .rdIdx(rdIdx), .statusWord(statusWord), .txIrq(txIrq)
  );

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) wbMem[(memAddr >> 4) % NSLOT] <= memWrData;
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rstN && outValid) begin
      gotBytes.push_back(outByte);
      if (outLast) begin
        gotLens.push_back(gotRun + 1);
        gotRun = 0;
      end else begin
        gotRun = gotRun + 1;
      end
    end
    if (rstN && txIrq) irqCnt = irqCnt + 1;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byteAt(int unsigned a);
    return mem[a >> 3][8 * (a & 7) +: 8];
  endfunction

  // Descriptor in slot: header length len, inl inline bytes, segment lengths,
  // s2only sets bit 26 without bit 25 (segment 2 must then be ignored).
  task automatic makeDesc(int slot, int len, int inl, int s1len, int s2len,
                          bit s2only, bit ien, logic [3:0] err);
    int off, base, sa1, sa2, tot;
    bit s1, s2bit, tl;
    logic [63:0] hdr;
    logic [7:0] q[$];
    off = (inl > 0) ? 128 - inl : 0;
    s1 = (s1len > 0);
    s2bit = (s2len > 0);
    base = slot * 16;
    sa1 = 256 + slot * 96;
    sa2 = sa1 + 48;
    hdr = 64'(len - 1) | (64'(off) << 16) | (64'(ien) << 24)
        | (64'(s1) << 25) | (64'(s2bit) << 26);
    mem[base] = hdr;
    for (int w = 1; w < 16; w++) mem[base + w] = {$urandom, $urandom};
    for (int w = 0; w < 96; w++) mem[sa1 + w] = {$urandom, $urandom};
    if (s1) mem[base + 1] = 64'(s1len - 1) | (64'(sa1) << 16);
    if (s2bit) mem[base + 2] = 64'(s2len - 1) | (64'(sa2) << 16);
    if (s2only) mem[base + 1] = {$urandom, $urandom};
    if (inl > 0)
      for (int b = off; b < 128; b++) q.push_back(byteAt(base * 8 + b));
    if (s1) begin
      for (int i = 0; i < s1len; i++) q.push_back(byteAt(sa1 * 8 + i));
      if (s2bit) for (int i = 0; i < s2len; i++) q.push_back(byteAt(sa2 * 8 + i));
    end
    tl = (len > 1518);
    if (!tl) begin
      tot = (len < 60) ? 60 : len;
      for (int i = 0; i < tot; i++) expBytes.push_back((i < q.size()) ? q[i] : 8'd0);
      expLens.push_back(tot);
    end
    errPlan[slot] = err;
    expWb[slot] = hdr | (64'd1 << 32) | (64'(!tl && err == 4'd0) << 33)
                | (64'(tl) << 34) | (tl ? 64'd0 : (64'(err) << 35));
    if (ien) expIrq++;
  endtask

  task automatic post(int n);
    @(negedge clk);
    wrIdx = IDX_W'(wrIdx + n);
  endtask

  task automatic finish(int first, int n, string tag);
    while (rdIdx != wrIdx) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rdIdx == wrIdx, "R2", {tag, " rdIdx caught up"}, rdIdx, wrIdx);
    chk(statusWord[16 +: IDX_W] == rdIdx && statusWord[0] == 1'b0, "R2",
        {tag, " statusWord index"}, statusWord, 32'(rdIdx) << 16);
    chk(gotLens.size() == expLens.size(), "R9", {tag, " frame count"},
        gotLens.size(), expLens.size());
    if (gotLens.size() == expLens.size()) begin
      int p = 0;
      foreach (expLens[f]) begin
        int bad = -1;
        chk(gotLens[f] == expLens[f], "R5", {tag, " frame length"}, gotLens[f], expLens[f]);
        for (int i = 0; i < expLens[f]; i++)
          if (bad < 0 && gotBytes[p + i] !== expBytes[p + i]) bad = i;
        chk(bad < 0, "R3/R4", {tag, " frame bytes"}, bad < 0 ? 0 : gotBytes[p + bad],
            bad < 0 ? 0 : expBytes[p + bad]);
        p += expLens[f];
      end
    end
    for (int k = 0; k < n; k++) begin
      int s = (first + k) % NSLOT;
      chk(wbMem[s] == expWb[s], "R7", {tag, " header write-back"}, wbMem[s], expWb[s]);
    end
    chk(irqCnt == expIrq, "R8", {tag, " irq pulses"}, irqCnt, expIrq);
    expBytes.delete(); gotBytes.delete(); expLens.delete(); gotLens.delete();
    irqCnt = 0; expIrq = 0;
  endtask

  initial begin
    int s, firstK, n, len, inl, s1l, s2l;
    void'($urandom(32'd1234));
    for (int i = 0; i < NSLOT; i++) errPlan[i] = 4'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdIdx == 0 && statusWord == 0, "R1", "index after reset", statusWord, 0);
    chk(!outValid && !outLast && !txIrq && !memRdEn && !memWrEn, "R1",
        "outputs quiet in reset", {outValid, outLast, txIrq, memRdEn, memWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !memRdEn && !memWrEn && rdIdx == 0, "R1", "quiet after reset",
        {outValid, memRdEn, memWrEn}, 0);

    // R2 latency, R3 inline only, R8 irq enabled
    makeDesc(0, 60, 60, 0, 0, 0, 1, 4'd0);
    post(1);
    firstK = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (outValid && firstK == 0) firstK = k;
    end
    chk(firstK == 6, "R2", "first byte latency", firstK, 6);
    finish(0, 1, "inline");

    // R5 padding of a short inline frame; R7 error bits; irq disabled
    makeDesc(1, 20, 20, 0, 0, 0, 0, 4'b1010);
    post(1);
    finish(1, 1, "short pad");

    // R4 seg2 bit alone ignored; R3 offset zero with seg1 only; truncation R5
    makeDesc(2, 100, 0, 0, 200, 1, 1, 4'd0);
    makeDesc(3, 90, 0, 150, 0, 0, 0, 4'd0);
    makeDesc(4, 400, 40, 100, 120, 0, 1, 4'b0001);
    post(3);
    finish(2, 3, "segments");

    // R6 too-long boundary: 1518 accepted (zero tail), 1519 rejected
    makeDesc(5, 1518, 30, 200, 0, 0, 1, 4'd0);
    makeDesc(6, 1519, 30, 200, 0, 0, 1, 4'b0100);
    makeDesc(7, 2000, 0, 0, 0, 0, 0, 4'd0);
    post(3);
    finish(5, 3, "too long");

    // random batches across wrap, at most 7 outstanding
    for (int b = 0; b < 10; b++) begin
      s = int'(wrIdx);
      n = 1 + ($urandom % 7);
      for (int k = 0; k < n; k++) begin
        inl = ($urandom % 3 == 0) ? 0 : 1 + ($urandom % 100);
        s1l = ($urandom % 4 == 0) ? 0 : 1 + ($urandom % 300);
        s2l = (s1l > 0 && $urandom % 2 == 0) ? 1 + ($urandom % 300) : 0;
        len = ($urandom % 5 == 0) ? 1 + ($urandom % 59)
            : ($urandom % 10 == 0) ? 1519 + ($urandom % 100)
            : 1 + ($urandom % (inl + s1l + s2l + 100));
        makeDesc((s + k) % NSLOT, len, inl, s1l, s2l, 0, ($urandom % 2) == 1,
                 ($urandom % 3 == 0) ? 4'($urandom) : 4'd0);
      end
      post(n);
      finish(s, n, "random");
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule